// File: doc/BRIEF.md
# Stereo Serial Audio Input Receiver

This block turns a two-channel serial PCM stream into a pair of parallel sample words. It watches a bit clock, a frame clock that toggles once per channel, and a serial data line, and rebuilds one left word and one right word per frame. Each word is sign-extended to 24 bits and both words are handed out together with a single-cycle strobe once the right-channel word of a frame is complete.

The framing format, the word length and the meaning of the frame-clock level are static configuration inputs that a control block drives. Two framings are supported. In the right-justified framing, the word is aligned to the end of its half-frame. In the I2S framing, the word starts one bit after the frame-clock transition. By default the block runs on a faster system clock and detects bit-clock rising edges through a short synchronizer. Setting the synchronizer depth to zero instead clocks the block straight from the bit clock, and every clock edge then counts as a bit.

Top module: `pcm_stereo_deser`

## Requirements
- R1: While reset is applied and on the first cycle after it is released, `left_o` and `right_o` are zero and `valid_o` is low.
- R2: With `cfg_i2s` low (right-justified), a channel word is formed from the last N bits sampled on bit-clock rising edges before the frame-clock transition that closes its half-frame, MSB first.
- R3: With `cfg_i2s` high (I2S), the MSB of a word is the bit sampled on the second bit-clock rise of its half-frame, one bit after the frame-clock transition, and the next N-1 rises carry the remaining bits.
- R4: `cfg_wlen` selects the word length N: code 00 gives 16 bits, 01 gives 20 bits, 10 gives 24 bits.
- R5: The code 11 on `cfg_wlen` behaves exactly as 16 bits.
- R6: With `cfg_lr_swap` low, a half-frame with the frame clock high carries the left word and low carries the right word. With `cfg_lr_swap` high, the assignment is reversed.
- R7: Each output is the N-bit two's-complement word sign-extended to 24 bits. Bits 23 down to N-1 are all equal.
- R8: In I2S framing, bits beyond the first N in a half-frame have no effect on the word.
- R9: In right-justified framing, bits that come before the last N in a half-frame have no effect on the word.
- R10: `valid_o` is a one-cycle pulse raised once per frame, after the right word is complete. `left_o` and `right_o` change only in that cycle, and both are updated together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (or the bit clock itself when the synchronizer depth is 0) |
| rst_n | input | 1 | Synchronous active-low reset |
| bclk_in | input | 1 | Serial bit clock; data is sampled on its rising edge |
| lrclk_in | input | 1 | Frame clock, one period per stereo sample |
| sdata_in | input | 1 | Serial audio data, MSB first |
| cfg_i2s | input | 1 | 0: right-justified framing, 1: I2S framing |
| cfg_wlen | input | 2 | Word length code (00=16, 01=20, 10=24, 11=16) |
| cfg_lr_swap | input | 1 | 0: frame clock high is left, 1: frame clock high is right |
| left_o | output | 24 | Sign-extended left sample |
| right_o | output | 24 | Sign-extended right sample |
| valid_o | output | 1 | One-cycle strobe when a new left/right pair is presented |

## Verification
The checker watches four things on every cycle: the reset values, the one-cycle width of the strobe, that the output words hold steady between strobes, and that the sign-extension bits match the selected word length. Whether the right bits land in the right word cannot be seen cycle by cycle. That covers the end-aligned and start-aligned framings, the three word lengths and the reserved code, the channel swap, and the padding bits being ignored. Only the bench scenarios show these, by sending known frames and comparing the presented pairs.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;
    localparam int SAMPLE_W = 24;
    localparam int CNT_W    = $clog2(SAMPLE_W + 1);

    // Map the word-length code to a bit count; the spare code falls back to 16.
    function automatic logic [CNT_W-1:0] wlen_bits(input logic [1:0] code);
        case (code)
            2'b01:   wlen_bits = CNT_W'(20);
            2'b10:   wlen_bits = CNT_W'(24);
            default: wlen_bits = CNT_W'(16);
        endcase
    endfunction

    // Keep the low n bits of raw and copy bit n-1 into every higher position.
    function automatic logic [SAMPLE_W-1:0] sign_extend(input logic [SAMPLE_W-1:0] raw,
                                                        input logic [CNT_W-1:0] n);
        logic [SAMPLE_W-1:0] res;
        for (int i = 0; i < SAMPLE_W; i++)
            res[i] = (i < int'(n)) ? raw[i] : raw[n - 1'b1];
        return res;
    endfunction
endpackage

// File: rtl/pcm_rx_sync.sv
// Brings the serial inputs into the clk domain and flags bit-clock rising edges.
// Assumes the bit clock is slower than clk / 2 when SYNC_STAGES > 0. With
// SYNC_STAGES == 0, clk is the bit clock and every edge is a bit.
module pcm_rx_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk_in,
    input  logic lrclk_in,
    input  logic sdata_in,
    output logic bit_rise,
    output logic lr_s,
    output logic d_s
);
    generate
        if (SYNC_STAGES > 0) begin : g_sync
            logic [SYNC_STAGES-1:0] bclk_p, lr_p, d_p;
            logic                   bclk_old;

            // Shift all three inputs through equal-depth pipelines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    bclk_p   <= '0;
                    lr_p     <= '0;
                    d_p      <= '0;
                    bclk_old <= 1'b0;
                end else begin
                    bclk_p   <= {bclk_p[SYNC_STAGES-1:0], bclk_in} >> 0;
                    lr_p     <= {lr_p[SYNC_STAGES-1:0], lrclk_in} >> 0;
                    d_p      <= {d_p[SYNC_STAGES-1:0], sdata_in} >> 0;
                    bclk_old <= bclk_p[SYNC_STAGES-1];
                end
            end

            assign bit_rise = bclk_p[SYNC_STAGES-1] & ~bclk_old;
            assign lr_s     = lr_p[SYNC_STAGES-1];
            assign d_s      = d_p[SYNC_STAGES-1];
        end else begin : g_direct
            logic unused_bclk;
            assign unused_bclk = bclk_in;
            assign bit_rise    = 1'b1;
            assign lr_s        = lrclk_in;
            assign d_s         = sdata_in;
        end
    endgenerate
endmodule

// File: rtl/pcm_rx_shift.sv
// Collects the bits of each half-frame and emits the finished word when the
// frame clock changes. Right-justified: keeps the latest N bits before the
// change. I2S: takes N bits starting one bit after the change, including the
// bit sampled on the closing edge itself.
module pcm_rx_shift
    import pcm_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_rise,
    input  logic                lr_s,
    input  logic                d_s,
    input  logic                cfg_i2s,
    input  logic [CNT_W-1:0]    nbits,
    output logic                word_done,
    output logic                word_lr,
    output logic [SAMPLE_W-1:0] word
);
    logic                started, lr_prev;
    logic [SAMPLE_W-1:0] shreg, shifted;
    logic [CNT_W-1:0]    cnt;
    logic                room;

    assign shifted = {shreg[SAMPLE_W-2:0], d_s};
    assign room    = (cnt < nbits);

    // Shift on each bit rise and close out the word on each frame-clock change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started   <= 1'b0;
            lr_prev   <= 1'b0;
            shreg     <= '0;
            cnt       <= '0;
            word_done <= 1'b0;
            word_lr   <= 1'b0;
            word      <= '0;
        end else begin
            word_done <= 1'b0;
            if (bit_rise) begin
                started <= 1'b1;
                lr_prev <= lr_s;
                if (started && (lr_s != lr_prev)) begin
                    word_done <= 1'b1;
                    word_lr   <= lr_prev;
                    if (cfg_i2s) begin
                        word  <= sign_extend(room ? shifted : shreg, nbits);
                        shreg <= '0;
                    end else begin
                        word  <= sign_extend(shreg, nbits);
                        shreg <= shifted;
                    end
                    cnt <= '0;
                end else if (!cfg_i2s) begin
                    shreg <= shifted;
                end else if (room) begin
                    shreg <= shifted;
                    cnt   <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/pcm_rx_pair.sv
// Holds the left word until the matching right word arrives, then presents
// both with a one-cycle strobe. Assumes left comes before right in a frame.
module pcm_rx_pair
    import pcm_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                word_done,
    input  logic                word_is_left,
    input  logic [SAMPLE_W-1:0] word,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    logic [SAMPLE_W-1:0] left_hold;

    // Park left words and release the pair on each right word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_hold <= '0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (word_done && word_is_left) begin
                left_hold <= word;
            end else if (word_done) begin
                left_o  <= left_hold;
                right_o <= word;
                valid_o <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/pcm_stereo_deser.sv
// Top of the stereo serial receiver: synchronizer, word shifter, pair stage.
// Assumes the configuration inputs stay static while data flows.
module pcm_stereo_deser
    import pcm_rx_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bclk_in,
    input  logic                lrclk_in,
    input  logic                sdata_in,
    input  logic                cfg_i2s,
    input  logic [1:0]          cfg_wlen,
    input  logic                cfg_lr_swap,
    output logic [SAMPLE_W-1:0] left_o,
    output logic [SAMPLE_W-1:0] right_o,
    output logic                valid_o
);
    logic                bit_rise, lr_s, d_s;
    logic                word_done, word_lr;
    logic [SAMPLE_W-1:0] word;
    logic [CNT_W-1:0]    nbits;

    assign nbits = wlen_bits(cfg_wlen);

    pcm_rx_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk_in), .lrclk_in(lrclk_in),
        .sdata_in(sdata_in), .bit_rise(bit_rise), .lr_s(lr_s), .d_s(d_s)
    );

    pcm_rx_shift u_shift (
        .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .lr_s(lr_s), .d_s(d_s),
        .cfg_i2s(cfg_i2s), .nbits(nbits), .word_done(word_done),
        .word_lr(word_lr), .word(word)
    );

    pcm_rx_pair u_pair (
        .clk(clk), .rst_n(rst_n), .word_done(word_done),
        .word_is_left(word_lr ^ cfg_lr_swap), .word(word),
        .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
    );
endmodule

// File: rtl/pcm_stereo_deser_chk.sv
// Cycle-level checks on the receiver outputs, attached by bind.
module pcm_stereo_deser_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [1:0]  cfg_wlen,
    input logic [23:0] left_o,
    input logic [23:0] right_o,
    input logic        valid_o
);
    assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!valid_o && left_o == 24'd0 && right_o == 24'd0));

    assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    assert_left_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(left_o));

    assert_right_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(right_o));

    assert_sext16_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wlen == 2'b00 || cfg_wlen == 2'b11) |->
        ((left_o[23:15] == 9'h000 || left_o[23:15] == 9'h1FF) &&
         (right_o[23:15] == 9'h000 || right_o[23:15] == 9'h1FF)));

    assert_sext20_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wlen == 2'b01) |->
        ((left_o[23:19] == 5'h00 || left_o[23:19] == 5'h1F) &&
         (right_o[23:19] == 5'h00 || right_o[23:19] == 5'h1F)));
endmodule

bind pcm_stereo_deser pcm_stereo_deser_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_wlen(cfg_wlen),
    .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
);

// File: tb/pcm_stereo_deser_test.sv
module pcm_stereo_deser_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
    logic        cfg_i2s = 1'b0, cfg_swap = 1'b0;
    logic [1:0]  cfg_wlen = 2'b00;
    logic [23:0] left_o, right_o;
    logic        valid_o;

    int checks = 0, errors = 0;
    int vcount = 0;
    logic [23:0] cap_l [0:7];
    logic [23:0] cap_r [0:7];
    logic carry = 1'b0;
    bit   done = 1'b0;

    localparam int HALF = 32;

    always #10 clk = ~clk;

    pcm_stereo_deser uut (
        .clk(clk), .rst_n(rst_n), .bclk_in(bclk), .lrclk_in(lrclk),
        .sdata_in(sdata), .cfg_i2s(cfg_i2s), .cfg_wlen(cfg_wlen),
        .cfg_lr_swap(cfg_swap), .left_o(left_o), .right_o(right_o),
        .valid_o(valid_o)
    );

    // Capture every presented pair, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && valid_o) begin
            if (vcount < 8) begin
                cap_l[vcount] = left_o;
                cap_r[vcount] = right_o;
            end
            vcount = vcount + 1;
        end
    end

    function automatic logic [23:0] sext(input logic [23:0] v, input int n);
        logic [23:0] r;
        for (int i = 0; i < 24; i++) r[i] = (i < n) ? v[i] : v[n-1];
        return r;
    endfunction

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic slot(input logic lr, input logic d);
        @(negedge clk); bclk = 1'b0; lrclk = lr; sdata = d;
        repeat (3) @(negedge clk);
        @(negedge clk); bclk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // One half-frame; nominal bits are delayed by one slot in I2S framing.
    task automatic send_half(input logic lr, input logic [23:0] w, input int n);
        for (int j = 0; j < HALF; j++) begin
            logic nom;
            if (cfg_i2s) nom = (j < n) ? w[n-1-j] : 1'b1;
            else         nom = (j >= HALF - n) ? w[n-1-(j-(HALF-n))] : j[0];
            if (cfg_i2s) begin
                slot(lr, carry);
                carry = nom;
            end else begin
                slot(lr, nom);
            end
        end
    endtask

    task automatic start(input logic i2s, input logic [1:0] wl, input logic swp);
        @(negedge clk); rst_n = 1'b0; bclk = 1'b0;
        cfg_i2s = i2s; cfg_wlen = wl; cfg_swap = swp;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; vcount = 0; carry = 1'b0;
    endtask

    // Send two frames after a right-channel lead-in and check both pairs.
    task automatic run_frames(input string req, input int n,
                              input logic [23:0] l0, input logic [23:0] r0,
                              input logic [23:0] l1, input logic [23:0] r1);
        logic lvl_l, lvl_r;
        lvl_l = ~cfg_swap;
        lvl_r = cfg_swap;
        send_half(lvl_r, 24'h0, n);
        send_half(lvl_l, l0, n);
        send_half(lvl_r, r0, n);
        send_half(lvl_l, l1, n);
        send_half(lvl_r, r1, n);
        send_half(lvl_l, 24'h0, n);
        repeat (10) @(negedge clk);
        checks++;
        if (vcount != 3) begin
            errors++;
            $display("FAIL R10 %s: actual %0d strobes expected 3", req, vcount);
        end else begin
            check(req, cap_l[1], sext(l0, n));
            check(req, cap_r[1], sext(r0, n));
            check(req, cap_l[2], sext(l1, n));
            check(req, cap_r[2], sext(r1, n));
        end
    endtask

    task automatic t_reset_R1;
        start(1'b0, 2'b00, 1'b0);
        check("R1 left", left_o, 24'h0);
        check("R1 right", right_o, 24'h0);
        check("R1 valid", {23'h0, valid_o}, 24'h0);
    endtask

    task automatic t_rj_R2;
        start(1'b0, 2'b00, 1'b0);
        run_frames("R2/R9 rj16", 16, 24'h00_1234, 24'h00_8001, 24'h00_7FFF, 24'h00_A5C3);
        start(1'b0, 2'b01, 1'b0);
        run_frames("R2/R4 rj20", 20, 24'h0_89ABC, 24'h0_12345, 24'h0_FFFFF, 24'h0_80000);
        start(1'b0, 2'b10, 1'b0);
        run_frames("R2/R4 rj24", 24, 24'h7F_00FF, 24'h80_1234, 24'hC3_5A01, 24'h01_0203);
    endtask

    task automatic t_i2s_R3;
        start(1'b1, 2'b00, 1'b0);
        run_frames("R3/R8 i2s16", 16, 24'h00_F00F, 24'h00_0001, 24'h00_8000, 24'h00_3C3C);
        start(1'b1, 2'b01, 1'b0);
        run_frames("R3/R4 i2s20", 20, 24'h0_7FFFF, 24'h0_C0001, 24'h0_55555, 24'h0_AAAAA);
        start(1'b1, 2'b10, 1'b0);
        run_frames("R3/R4 i2s24", 24, 24'h80_0000, 24'h7F_FFFF, 24'h12_3456, 24'hFE_DCBA);
    endtask

    task automatic t_reserved_R5;
        start(1'b0, 2'b11, 1'b0);
        run_frames("R5 rj", 16, 24'h00_9ABC, 24'h00_0F0F, 24'h00_1111, 24'h00_FFFE);
        start(1'b1, 2'b11, 1'b0);
        run_frames("R5 i2s", 16, 24'h00_4321, 24'h00_C001, 24'h00_0002, 24'h00_8888);
    endtask

    task automatic t_swap_R6;
        start(1'b0, 2'b00, 1'b1);
        run_frames("R6 rj swap", 16, 24'h00_1357, 24'h00_9BDF, 24'h00_2468, 24'h00_ACE0);
        start(1'b1, 2'b10, 1'b1);
        run_frames("R6 i2s swap", 24, 24'hA1_B2C3, 24'h0D_0E0F, 24'h55_AA55, 24'h80_0001);
    endtask

    initial begin
        t_reset_R1();
        t_rj_R2();
        t_i2s_R3();
        t_reserved_R5();
        t_swap_R6();
        // R7 sign extension is covered by the negative words above (e.g. 8001, 80000).
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule